// File: doc/BRIEF.md
# SPI Boot Image Loader with Integrity Check

After reset, this block copies a fixed-size boot image from an external serial flash into a local program RAM. It uses SPI mode 0 and acts as the master. It pulls chip select low and sends a standard read command with a start address. It then clocks in 256 words of 32 bits. Each payload word goes out through a single-cycle write port as soon as it has been assembled.

The last word of the image is not stored. It is a seal. The block keeps a wrapping 32-bit sum of the 255 payload words. It XORs that sum with a fixed ASCII constant and compares the result with the seal. When the final bit has been clocked in, the block releases chip select. In the same cycle it raises a sticky done flag together with exactly one verdict flag, pass or fail. The flags hold until the next reset. A following stage waits for done before it starts the loaded program.

The serial clock runs at one eighth of the system clock. A complete load takes 8224 serial bits, which is 65,792 system clocks.

Top module: `bootld_spi_loader`

## Requirements
- R1: While reset is high, spi_cs_n is 1, spi_sclk is 0, spi_mosi is 0, ram_we is 0 and ld_done, ld_pass and ld_fail are all 0.
- R2: With AUTO_START=1, the first clock edge after reset falls drives spi_cs_n to 0. From then on spi_cs_n stays low for exactly 65,792 clocks. spi_sclk is 0 whenever spi_cs_n is 1.
- R3: Each serial bit lasts 8 clocks. spi_sclk is low for the first 4 clocks of the bit and high for the last 4.
- R4: The first 32 bits sent on spi_mosi are the byte 0x03 followed by the 24-bit address 0x000000, most significant bit first. spi_mosi changes only in the cycle where spi_sclk falls, and it is 0 after the header.
- R5: spi_miso is sampled at the rising edge of spi_sclk. Bytes arrive most significant bit first. A word is built from four bytes, the first byte received becoming bits 7:0 and the fourth byte becoming bits 31:24.
- R6: Payload word n (n = 0..254) is written with ram_we high for one clock at ram_addr n. This happens in the clock that follows the sampling edge of the word's last bit. The 256th word is never written.
- R7: If the 256th word equals (sum of words 0..254 mod 2^32) XOR 0x50726F70, then ld_pass is 1 and ld_fail is 0 once ld_done is set.
- R8: If the 256th word differs from that value, then ld_fail is 1 and ld_pass is 0 once ld_done is set.
- R9: ld_done and the verdict rise in the same clock that spi_cs_n returns high. They hold unchanged until reset.
- R10: Pulses on start have no effect while a load is running or after it has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a load from idle (used when AUTO_START=0) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Command and address to the flash |
| spi_miso | input | 1 | Data from the flash |
| ram_we | output | 1 | One-cycle write strobe for a payload word |
| ram_addr | output | $clog2(WORDS) (8) | Payload word index |
| ram_wdata | output | 32 | Assembled payload word |
| ld_done | output | 1 | Load finished (sticky) |
| ld_pass | output | 1 | Seal matched (sticky) |
| ld_fail | output | 1 | Seal mismatched (sticky) |

## Verification
The assertions assume a few things about the inputs:
- spi_miso changes only after a falling edge of spi_sclk and is stable at the rising edge.
- start is synchronous to clk.
- Reset lasts at least one clock.

The bench flash model drives its next data bit only from a falling serial clock edge, so every sample lands in a quiet window. Reset and start are driven on the falling system clock edge, away from the edge where the design samples them. Start pulses are placed in the middle of a transfer and after completion.

// File: rtl/bootld_pkg.sv
package bootld_pkg;

    localparam logic [7:0]  RD_CMD     = 8'h03;
    localparam logic [31:0] SEAL_XOR   = 32'h50726F70;
    localparam int          HDR_BITS   = 32;
    localparam int          WORD_BITS  = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_DONE
    } ld_state_e;

    typedef struct packed {
        logic                 vld;
        logic [WORD_BITS-1:0] data;
    } word_evt_t;

    function automatic logic hdr_bit(input logic [7:0] cmd,
                                     input logic [23:0] addr,
                                     input logic [4:0] idx);
        logic [31:0] h;
        h = {cmd, addr};
        return h[5'd31 - idx];
    endfunction

    function automatic logic [31:0] seal_of(input logic [31:0] sum);
        return sum ^ SEAL_XOR;
    endfunction

endpackage

// File: rtl/bootld_bitclk.sv
module bootld_bitclk #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk_lvl,
    output logic smp_tick,
    output logic end_tick
);
    localparam int PW   = $clog2(DIV);
    localparam int HALF = DIV / 2;

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_q <= '0;
        end else if (phase_q == PW'(DIV - 1)) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign sclk_lvl = run && (phase_q >= PW'(HALF));
    assign smp_tick = run && (phase_q == PW'(HALF - 1));
    assign end_tick = run && (phase_q == PW'(DIV - 1));

    // R3: a sample tick is followed by the high half of the bit
    a_r3_rise_after_sample: assert property (@(posedge clk) disable iff (rst)
        (smp_tick && run) |=> (!run || sclk_lvl));

    // R3: the bit ends while the clock is still high
    a_r3_end_in_high: assert property (@(posedge clk) disable iff (rst)
        end_tick |-> sclk_lvl);

endmodule

// File: rtl/bootld_word_asm.sv
module bootld_word_asm
    import bootld_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      take,
    input  logic      bit_in,
    output word_evt_t evt
);
    logic [2:0]           bcnt_q;
    logic [1:0]           kcnt_q;
    logic [7:0]           byte_q;
    logic [WORD_BITS-1:0] acc_q;
    logic [7:0]           byte_nx;

    assign byte_nx = {byte_q[6:0], bit_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt_q <= '0;
            kcnt_q <= '0;
            byte_q <= '0;
            acc_q  <= '0;
            evt    <= '0;
        end else begin
            evt.vld <= 1'b0;
            if (take) begin
                byte_q <= byte_nx;
                bcnt_q <= bcnt_q + 1'b1;
                if (bcnt_q == 3'd7) begin
                    acc_q  <= {byte_nx, acc_q[WORD_BITS-1:8]};
                    kcnt_q <= kcnt_q + 1'b1;
                    if (kcnt_q == 2'd3) begin
                        evt.vld  <= 1'b1;
                        evt.data <= {byte_nx, acc_q[WORD_BITS-1:8]};
                    end
                end
            end
        end
    end

    // R5: a completed word is reported for a single cycle
    a_r5_word_pulse: assert property (@(posedge clk) disable iff (rst)
        evt.vld |=> !evt.vld);

endmodule

// File: rtl/bootld_sum_check.sv
module bootld_sum_check
    import bootld_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  word_evt_t evt,
    input  logic      is_last,
    output logic      ok_q
);
    logic [WORD_BITS-1:0] sum_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            ok_q  <= 1'b0;
        end else if (evt.vld) begin
            if (is_last) begin
                ok_q <= (evt.data == seal_of(sum_q));
            end else begin
                sum_q <= sum_q + evt.data;
            end
        end
    end

endmodule

// File: rtl/bootld_spi_loader.sv
module bootld_spi_loader
    import bootld_pkg::*;
#(
    parameter int          WORDS      = 256,
    parameter int          DIV        = 8,
    parameter logic [23:0] FLASH_ADDR = 24'h000000,
    parameter bit          AUTO_START = 1'b1,
    localparam int         AW         = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          spi_cs_n,
    output logic          spi_sclk,
    output logic          spi_mosi,
    input  logic          spi_miso,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [31:0]   ram_wdata,
    output logic          ld_done,
    output logic          ld_pass,
    output logic          ld_fail
);
    localparam int TOTAL = HDR_BITS + WORDS * WORD_BITS;
    localparam int BW    = $clog2(TOTAL);

    ld_state_e     st_q;
    logic [BW-1:0] bit_q;
    logic [AW-1:0] word_q;
    logic          run;
    logic          sclk_lvl;
    logic          smp_tick;
    logic          end_tick;
    logic          in_data;
    logic          is_last;
    logic          ok_q;
    word_evt_t     evt;

    assign run     = (st_q == ST_XFER);
    assign in_data = (bit_q >= BW'(HDR_BITS));
    assign is_last = (word_q == AW'(WORDS - 1));

    bootld_bitclk #(.DIV(DIV)) u_bitclk (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .sclk_lvl (sclk_lvl),
        .smp_tick (smp_tick),
        .end_tick (end_tick)
    );

    bootld_word_asm u_asm (
        .clk    (clk),
        .rst    (rst),
        .take   (smp_tick && in_data),
        .bit_in (spi_miso),
        .evt    (evt)
    );

    bootld_sum_check u_chk (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .is_last (is_last),
        .ok_q    (ok_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            bit_q   <= '0;
            word_q  <= '0;
            ld_done <= 1'b0;
            ld_pass <= 1'b0;
            ld_fail <= 1'b0;
        end else begin
            if (evt.vld) begin
                word_q <= word_q + 1'b1;
            end
            unique case (st_q)
                ST_IDLE: begin
                    if (AUTO_START || start) begin
                        st_q <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (end_tick) begin
                        if (bit_q == BW'(TOTAL - 1)) begin
                            st_q    <= ST_DONE;
                            ld_done <= 1'b1;
                            ld_pass <= ok_q;
                            ld_fail <= !ok_q;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                default: st_q <= ST_DONE;
            endcase
        end
    end

    assign spi_cs_n  = !run;
    assign spi_sclk  = sclk_lvl;
    assign spi_mosi  = run && !in_data && hdr_bit(RD_CMD, FLASH_ADDR, bit_q[4:0]);
    assign ram_we    = evt.vld && !is_last;
    assign ram_addr  = word_q;
    assign ram_wdata = evt.data;

    // R2: serial clock idles low while deselected
    a_r2_sclk_idle: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    // R4: data out only moves on a falling serial clock
    a_r4_mosi_hold: assert property (@(posedge clk) disable iff (rst)
        (!spi_cs_n && !$past(spi_cs_n) && !$fell(spi_sclk)) |-> $stable(spi_mosi));

    // R6: write strobe lasts one cycle and only during a transfer
    a_r6_we_pulse: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> !ram_we);
    a_r6_we_in_xfer: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> !spi_cs_n);

    // R7/R8: exactly one verdict, and only with done
    a_r8_one_verdict: assert property (@(posedge clk) disable iff (rst)
        ld_done |-> (ld_pass ^ ld_fail));
    a_r7_verdict_needs_done: assert property (@(posedge clk) disable iff (rst)
        (ld_pass || ld_fail) |-> ld_done);

    // R9: done and verdict are sticky, chip select stays released
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        ld_done |=> (ld_done && $stable(ld_pass) && $stable(ld_fail) && spi_cs_n));

endmodule

// File: tb/bootld_spi_loader_tb_top.sv
module bootld_spi_loader_tb_top;
    localparam int WORDS    = 256;
    localparam int DIV      = 8;
    localparam int XFER_CYC = (32 + WORDS * 32) * DIV;
    localparam logic [31:0] HDR  = 32'h0300_0000;
    localparam logic [31:0] SEAL = 32'h5072_6F70;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       spi_miso = 1'b0;
    logic       spi_cs_n, spi_sclk, spi_mosi, ram_we;
    logic [7:0] ram_addr;
    logic [31:0] ram_wdata;
    logic       ld_done, ld_pass, ld_fail;

    always #2 clk = ~clk;

    bootld_spi_loader dut_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .spi_cs_n  (spi_cs_n),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ld_done   (ld_done),
        .ld_pass   (ld_pass),
        .ld_fail   (ld_fail)
    );

    int          checks = 0;
    int          fails  = 0;
    int          t      = 0;
    bit          running = 1'b0;
    bit          exp_ok;
    logic [31:0] img    [WORDS];
    logic [31:0] ram_cp [WORDS];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (t=%0d)", tag, act, exp, t);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // edges seen since reset fell
    always @(posedge clk) begin
        if (rst) t <= 0;
        else     t <= t + 1;
    end

    // flash model: shifts header in, shifts image out on falling sclk
    int          rises = 0;
    logic [31:0] hdr_cap = '0;

    function automatic logic stream_bit(input int d);
        int w, j;
        w = d / 32;
        j = d % 32;
        return img[w][8 * (j / 8) + 7 - (j % 8)];
    endfunction

    always @(negedge spi_cs_n) begin
        rises    = 0;
        spi_miso = 1'b0;
    end

    always @(posedge spi_sclk) begin
        if (rises < 32) hdr_cap = {hdr_cap[30:0], spi_mosi};
        rises++;
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n && rises >= 32 && (rises - 32) < WORDS * 32)
            spi_miso = stream_bit(rises - 32);
    end

    // cycle-by-cycle reference model
    bit busy, e_sclk, e_mosi, e_we, e_done;
    int k, b, ph, w;

    always @(negedge clk) begin
        if (running) begin
            busy   = (t >= 1) && (t <= XFER_CYC);
            k      = t - 1;
            b      = busy ? k / DIV : 0;
            ph     = busy ? k % DIV : 0;
            w      = (b - 32) / 32;
            e_sclk = busy && (ph >= DIV / 2);
            e_mosi = busy && (b < 32) && HDR[31 - (b % 32)];
            e_we   = busy && (ph == DIV / 2) && (b >= 32) && ((b - 32) % 32 == 31) && (w < WORDS - 1);
            e_done = (t > XFER_CYC);
            chk("R2 cs_n", spi_cs_n, !busy);
            chk("R3 sclk", spi_sclk, e_sclk);
            chk("R4 mosi", spi_mosi, e_mosi);
            chk("R6 we", ram_we, e_we);
            if (e_we) begin
                chk("R6 addr", ram_addr, w);
                chk("R5 data", ram_wdata, img[w]);
            end
            chk("R9 done", ld_done, e_done);
            chk("R7 pass", ld_pass, e_done && exp_ok);
            chk("R8 fail", ld_fail, e_done && !exp_ok);
            if (ram_we) ram_cp[ram_addr] = ram_wdata;
        end
    end

    task automatic load(input logic [31:0] seed, input bit corrupt);
        logic [31:0] sum;
        sum = '0;
        for (int i = 0; i < WORDS - 1; i++) begin
            img[i] = (seed ^ (i * 32'h9E37_79B9)) + (i << 20);
            if (i == 0) img[i] = 32'hFFFF_FFFF;
            sum += img[i];
        end
        img[WORDS-1] = (sum ^ SEAL) ^ (corrupt ? 32'h0000_0100 : 32'h0);
        exp_ok = !corrupt;
        for (int i = 0; i < WORDS; i++) ram_cp[i] = 32'hDEAD_BEEF;

        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 cs_n", spi_cs_n, 1);
        chk("R1 sclk", spi_sclk, 0);
        chk("R1 mosi", spi_mosi, 0);
        chk("R1 we", ram_we, 0);
        chk("R1 flags", {ld_done, ld_pass, ld_fail}, 0);
        rst = 1'b0;
        running = 1'b1;

        repeat (1000) @(negedge clk);
        start = 1'b1;                        // R10: ignored mid-transfer
        @(negedge clk);
        start = 1'b0;
        repeat (40000) @(negedge clk);
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        while (t <= XFER_CYC + 2) @(negedge clk);

        for (int i = 0; i < WORDS - 1; i++) chk("R6 ram", ram_cp[i], img[i]);
        chk("R6 seal not written", ram_cp[WORDS-1], 32'hDEAD_BEEF);
        chk("R4 header", hdr_cap, HDR);
        chk("R7 pass end", ld_pass, exp_ok);
        chk("R8 fail end", ld_fail, !exp_ok);

        start = 1'b1;                        // R10: ignored after done
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        chk("R10 cs_n", spi_cs_n, 1);
        chk("R10 done", ld_done, 1);
        running = 1'b0;
    endtask

    initial begin
        load(32'h1234_5678, 1'b0);
        load(32'hCAFE_0001, 1'b1);
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

endmodule